// File: doc/BRIEF.md
# Compact JTAG Bridge

This block sits on the target side of a two-wire debug link. It watches a link clock (`tckc`) and a link data line (`tmsc`), both already synchronous to the local clock `clk`, and drives clean four-wire signals for a downstream TAP. The TAP signals are a one-cycle clock strobe, TMS and TDI, plus a flag that marks when the target owns the data line so that it can drive TDO.

The bridge starts in plain pass-through mode. It counts how often `tmsc` toggles while `tckc` is high and evaluates that count at the next rising edge of `tckc`. One count value starts an activation sequence. During that sequence the bridge steps through a fixed series of header phases, with an optional long form. When the sequence completes, the bridge switches to a three-slot serial scan format. In that format every three link clocks carry inverted TDI, TMS and a TDO turnaround slot, and together they produce one TAP clock. A larger count always returns the link to pass-through.

Status outputs report the mode and the activation phase.

Top module: `ctj_bridge`

## Requirements
- R1: After reset: `mode` = 0 (pass-through), `phase` = 0, and `tap_tck`, `tap_tms`, `tap_tdi`, `tdo_slot` and `tap_reset` are all 0. `mode` never takes the value 3.
- R2: In pass-through mode (`mode` 0) and in activation (`mode` 1), each rising edge of `tckc` gives a single-cycle `tap_tck` pulse. On that pulse, `tap_tms` equals the `tmsc` level at the rising edge and `tap_tdi` is 0. No `tap_tck` pulse occurs without a rising edge of `tckc`.
- R3: Toggles of `tmsc` are counted while `tckc` is high. The count is evaluated at the next rising edge of `tckc` and then cleared. A count of 8 or more forces `mode` 0 from any mode, and that edge is handled as a pass-through edge.
- R4: A count of exactly 6 enters activation from any mode: `mode` 1, `phase` 1, position 0, code length 12. That edge is handled as a pass-through edge. Any other nonzero count below 8 has no effect, and the edge is processed normally in the current mode.
- R5: In activation, each later rising edge advances the position by one. If `tmsc` is 0 on the edge that reaches position 8, the code length becomes 36.
- R6: `phase` is 0 whenever `mode` is not 1. In activation: positions 0 to 4 give `phase` 1, positions 5 to 8 give `phase` 2, and with length 12, positions 9 to 12 give `phase` 10.
- R7: With length 36, `phase` follows the position: 9–13 → 3, 14–16 → 4, 17–18 → 5, 19–23 → 6, 24–25 → 7, 26–27 → 8, 28–32 → 9, 33–36 → 10.
- R8: The rising edge that moves the position past the code length sets `mode` 2 and `phase` 0. It gives a single-cycle `tap_reset` pulse, gives no `tap_tck` on that edge, and starts the scan at slot 1.
- R9: In scan mode, slot 0 latches TDI as the inverse of `tmsc` and slot 1 latches TMS from `tmsc`. `tdo_slot` is 1 from the slot-1 edge until the slot-2 edge.
- R10: In scan mode, the slot-2 edge gives exactly one `tap_tck` pulse. The pulse carries the TMS and TDI latched in that group. The first group after entry has no slot 0, so it carries TDI 0.
- R11: An escape evaluated on an edge that would be a scan slot takes precedence over the slot. A count of 8 on the slot-2 edge gives a pass-through pulse with `tap_tms` equal to `tmsc` and `tap_tdi` 0, instead of the group's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; the link inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| tckc | input | 1 | Link clock |
| tmsc | input | 1 | Link data, as received |
| tap_tck | output | 1 | One-cycle TAP clock strobe |
| tap_tms | output | 1 | TMS for the downstream TAP, held between strobes |
| tap_tdi | output | 1 | TDI for the downstream TAP, held between strobes |
| tdo_slot | output | 1 | High while the target owns the data line for TDO |
| tap_reset | output | 1 | One-cycle request to reset the downstream TAP |
| mode | output | 2 | 0 pass-through, 1 activation, 2 three-slot scan |
| phase | output | 4 | Activation phase, 0 outside activation |

## Verification
The escape evaluation and the per-edge work of the current mode both happen on the same rising edge of the link clock. That edge can be a scan slot, an activation step or a pass-through bit. The bench toggles the data line during the high phase just before a slot-2 edge and a slot-0 edge. It then judges that a count of 8 replaces the group's TAP clock with a pass-through pulse, and that a count of 7 leaves the slot decode untouched. A reference model in the bench predicts every TAP pulse, which goes into a scoreboard queue. The bench also checks the mode and phase on every edge.

// File: rtl/ctj_pkg.sv
`timescale 1ns/1ps
// Shared types and protocol constants for the compact JTAG bridge.
// Assumes position values never exceed 2**POS_W - 1.
package ctj_pkg;

    localparam int POS_W = 6;

    typedef enum logic [1:0] {
        MODE_WIRE4    = 2'd0,
        MODE_ACTIVATE = 2'd1,
        MODE_SLOT3    = 2'd2
    } mode_t;

    typedef enum logic [3:0] {
        PH_NONE     = 4'd0,
        PH_ACT_CODE = 4'd1,
        PH_ESC_CTL  = 4'd2,
        PH_SPARE    = 4'd3,
        PH_TP_DELAY = 4'd4,
        PH_TP_REV   = 4'd5,
        PH_TP_STATE = 4'd6,
        PH_RDY_CNT  = 4'd7,
        PH_DLY_CNT  = 4'd8,
        PH_SCAN_FMT = 4'd9,
        PH_CHECK    = 4'd10
    } phase_t;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_PASS  = 2'd1,
        RK_ENTER = 2'd2,
        RK_SLOT  = 2'd3
    } rise_kind_t;

    localparam logic [POS_W-1:0] LEN_SHORT = POS_W'(12);
    localparam logic [POS_W-1:0] LEN_LONG  = POS_W'(36);
    localparam logic [POS_W-1:0] POS_EXT   = POS_W'(8);
    localparam int ESC_ACT   = 6;
    localparam int ESC_FORCE = 8;

    // Maps an activation position and code length to its header phase.
    function automatic phase_t phase_for(logic [POS_W-1:0] pos, logic is_long);
        if (pos <= POS_W'(4))       return PH_ACT_CODE;
        else if (pos <= POS_W'(8))  return PH_ESC_CTL;
        else if (!is_long)          return PH_CHECK;
        else if (pos <= POS_W'(13)) return PH_SPARE;
        else if (pos <= POS_W'(16)) return PH_TP_DELAY;
        else if (pos <= POS_W'(18)) return PH_TP_REV;
        else if (pos <= POS_W'(23)) return PH_TP_STATE;
        else if (pos <= POS_W'(25)) return PH_RDY_CNT;
        else if (pos <= POS_W'(27)) return PH_DLY_CNT;
        else if (pos <= POS_W'(32)) return PH_SCAN_FMT;
        else                        return PH_CHECK;
    endfunction

endpackage

// File: rtl/ctj_escape_mon.sv
`timescale 1ns/1ps
// Detects link-clock rising edges and counts data toggles while the link
// clock is high. The count is valid in the cycle of a rising edge and is
// cleared right after it. Assumes tckc/tmsc are synchronous to clk.
module ctj_escape_mon #(
    parameter int ESC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tckc,
    input  logic             tmsc,
    output logic             rise,
    output logic [ESC_W-1:0] esc_cnt
);
    localparam logic [ESC_W-1:0] CNT_MAX = {ESC_W{1'b1}};

    logic             tckc_q;
    logic             tmsc_q;
    logic [ESC_W-1:0] cnt_q;
    logic             toggle;

    // Edge and toggle detection against the previous samples.
    always_comb begin
        rise   = tckc & ~tckc_q;
        toggle = tckc & tckc_q & (tmsc ^ tmsc_q);
    end

    // Sample history and saturating escape counter, cleared on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tckc_q <= 1'b0;
            tmsc_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            tckc_q <= tckc;
            tmsc_q <= tmsc;
            if (rise)
                cnt_q <= '0;
            else if (toggle && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign esc_cnt = cnt_q;

endmodule

// File: rtl/ctj_act_seq.sv
`timescale 1ns/1ps
// Mode and activation sequencer. On each link rising edge it applies an
// escape decision first, then the current mode's step. It classifies the
// edge for the TAP driver. Assumes rise is a single-cycle strobe.
module ctj_act_seq
    import ctj_pkg::*;
#(
    parameter int ESC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             tmsc,
    input  logic [ESC_W-1:0] esc_cnt,
    output mode_t            mode,
    output phase_t           phase,
    output rise_kind_t       kind
);
    localparam logic [ESC_W-1:0] CNT_FORCE = ESC_W'(ESC_FORCE);
    localparam logic [ESC_W-1:0] CNT_ACT   = ESC_W'(ESC_ACT);

    mode_t            mode_q, mode_n;
    logic [POS_W-1:0] pos_q, pos_n, pos_inc;
    logic             long_q, long_n;

    // Next-state selection for one link edge.
    always_comb begin
        mode_n  = mode_q;
        pos_n   = pos_q;
        long_n  = long_q;
        kind    = RK_NONE;
        pos_inc = pos_q + 1'b1;
        if (rise) begin
            if (esc_cnt >= CNT_FORCE) begin
                mode_n = MODE_WIRE4;
                kind   = RK_PASS;
            end else if (esc_cnt == CNT_ACT) begin
                mode_n = MODE_ACTIVATE;
                pos_n  = '0;
                long_n = 1'b0;
                kind   = RK_PASS;
            end else begin
                case (mode_q)
                    MODE_ACTIVATE: begin
                        pos_n = pos_inc;
                        if (pos_inc == POS_EXT && !tmsc)
                            long_n = 1'b1;
                        if (pos_inc > (long_n ? LEN_LONG : LEN_SHORT)) begin
                            mode_n = MODE_SLOT3;
                            kind   = RK_ENTER;
                        end else begin
                            kind   = RK_PASS;
                        end
                    end
                    MODE_SLOT3: kind = RK_SLOT;
                    default: begin
                        mode_n = MODE_WIRE4;
                        kind   = RK_PASS;
                    end
                endcase
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_WIRE4;
            pos_q  <= '0;
            long_q <= 1'b0;
        end else begin
            mode_q <= mode_n;
            pos_q  <= pos_n;
            long_q <= long_n;
        end
    end

    // Status decode from the held state.
    always_comb begin
        mode  = mode_q;
        phase = (mode_q == MODE_ACTIVATE) ? phase_for(pos_q, long_q) : PH_NONE;
    end

endmodule

// File: rtl/ctj_tap_drive.sv
`timescale 1ns/1ps
// Builds the downstream TAP signals from the classified link edge.
// Pass edges strobe TCK at once. Scan edges gather TDI/TMS over three slots
// and strobe on slot 2. Assumes kind is RK_NONE except on a link edge.
module ctj_tap_drive
    import ctj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rise_kind_t kind,
    input  logic       tmsc,
    output logic       tap_tck,
    output logic       tap_tms,
    output logic       tap_tdi,
    output logic       tdo_slot,
    output logic       tap_reset
);
    logic [1:0] slot_q;
    logic       tms_hold;
    logic       tdi_hold;

    // Slot counter, gathered bits and registered TAP outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= 2'd0;
            tms_hold  <= 1'b0;
            tdi_hold  <= 1'b0;
            tap_tck   <= 1'b0;
            tap_tms   <= 1'b0;
            tap_tdi   <= 1'b0;
            tdo_slot  <= 1'b0;
            tap_reset <= 1'b0;
        end else begin
            tap_tck   <= 1'b0;
            tap_reset <= 1'b0;
            case (kind)
                RK_PASS: begin
                    tap_tck  <= 1'b1;
                    tap_tms  <= tmsc;
                    tap_tdi  <= 1'b0;
                    tdo_slot <= 1'b0;
                end
                RK_ENTER: begin
                    slot_q    <= 2'd1;
                    tdi_hold  <= 1'b0;
                    tap_reset <= 1'b1;
                    tdo_slot  <= 1'b0;
                end
                RK_SLOT: begin
                    case (slot_q)
                        2'd0: begin
                            tdi_hold <= ~tmsc;
                            slot_q   <= 2'd1;
                        end
                        2'd1: begin
                            tms_hold <= tmsc;
                            slot_q   <= 2'd2;
                            tdo_slot <= 1'b1;
                        end
                        default: begin
                            tap_tck  <= 1'b1;
                            tap_tms  <= tms_hold;
                            tap_tdi  <= tdi_hold;
                            slot_q   <= 2'd0;
                            tdo_slot <= 1'b0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctj_bridge.sv
`timescale 1ns/1ps
// Top of the compact JTAG bridge: escape monitor, mode sequencer and TAP
// driver in a chain. Assumes tckc/tmsc arrive already synchronized to clk.
module ctj_bridge
    import ctj_pkg::*;
#(
    parameter int ESC_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tckc,
    input  logic       tmsc,
    output logic       tap_tck,
    output logic       tap_tms,
    output logic       tap_tdi,
    output logic       tdo_slot,
    output logic       tap_reset,
    output logic [1:0] mode,
    output logic [3:0] phase
);
    logic             rise;
    logic [ESC_W-1:0] esc_cnt;
    mode_t            mode_s;
    phase_t           phase_s;
    rise_kind_t       kind;

    ctj_escape_mon #(.ESC_W(ESC_W)) u_esc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tckc    (tckc),
        .tmsc    (tmsc),
        .rise    (rise),
        .esc_cnt (esc_cnt)
    );

    ctj_act_seq #(.ESC_W(ESC_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .tmsc    (tmsc),
        .esc_cnt (esc_cnt),
        .mode    (mode_s),
        .phase   (phase_s),
        .kind    (kind)
    );

    ctj_tap_drive u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .tmsc      (tmsc),
        .tap_tck   (tap_tck),
        .tap_tms   (tap_tms),
        .tap_tdi   (tap_tdi),
        .tdo_slot  (tdo_slot),
        .tap_reset (tap_reset)
    );

    assign mode  = mode_s;
    assign phase = phase_s;

endmodule

// File: rtl/ctj_bridge_chk.sv
`timescale 1ns/1ps
// Temporal checks on the bridge ports, attached to every instance by bind.
module ctj_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tckc,
    input logic       tap_tck,
    input logic       tap_tdi,
    input logic       tdo_slot,
    input logic       tap_reset,
    input logic [1:0] mode,
    input logic [3:0] phase
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);                                               // R1
    AST_TCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tck |=> !tap_tck);                                       // R2
    AST_TCK_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tck |-> $past(tckc));                                    // R2
    AST_TDI_LOW_OUTSIDE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_tck && mode != 2'd2) |-> !tap_tdi);                     // R2
    AST_PHASE_ONLY_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1) |-> (phase == 4'd0));                         // R6
    AST_ENTER_NO_TCK: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |-> (!tap_tck && mode == 2'd2));                   // R8
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |=> !tap_reset);                                   // R8
    AST_TDO_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_slot |-> (mode == 2'd2));                                // R9
endmodule

bind ctj_bridge ctj_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tckc      (tckc),
    .tap_tck   (tap_tck),
    .tap_tdi   (tap_tdi),
    .tdo_slot  (tdo_slot),
    .tap_reset (tap_reset),
    .mode      (mode),
    .phase     (phase)
);

// File: tb/ctj_bridge_test.sv
`timescale 1ns/1ps
// Scoreboard bench: bit_in models each link edge, queues expected TAP
// pulses, and a negedge monitor pops and compares them.
module ctj_bridge_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tckc = 1'b0;
    logic       tmsc = 1'b0;
    logic       tap_tck, tap_tms, tap_tdi, tdo_slot, tap_reset;
    logic [1:0] mode;
    logic [3:0] phase;

    ctj_bridge uut (
        .clk(clk), .rst_n(rst_n), .tckc(tckc), .tmsc(tmsc),
        .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi),
        .tdo_slot(tdo_slot), .tap_reset(tap_reset),
        .mode(mode), .phase(phase)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic  tms;
        logic  tdi;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    int   m_mode = 0, m_pos = 0, m_len = 12, m_slot = 0, esc = 0;
    logic m_tms = 1'b0, m_tdi = 1'b0;

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_phase(int p, int len);
        if (p <= 4) return 1;
        if (p <= 8) return 2;
        if (len == 12) return 10;
        if (p <= 13) return 3;
        if (p <= 16) return 4;
        if (p <= 18) return 5;
        if (p <= 23) return 6;
        if (p <= 25) return 7;
        if (p <= 27) return 8;
        if (p <= 32) return 9;
        return 10;
    endfunction

    // Toggle the data line while the link clock is high.
    task automatic toggle(int n);
        repeat (n) begin
            @(negedge clk);
            tmsc = ~tmsc;
            esc++;
        end
    endtask

    // One link clock: model the expected result, drive the edge, check status.
    task automatic bit_in(logic v, string req);
        bit   exp_tck = 0;
        bit   exp_rst = 0;
        exp_t e;
        if (esc >= 8) begin
            m_mode = 0; exp_tck = 1;
            e.tms = v; e.tdi = 1'b0; e.req = req; q.push_back(e);
        end else if (esc == 6) begin
            m_mode = 1; m_pos = 0; m_len = 12; exp_tck = 1;
            e.tms = v; e.tdi = 1'b0; e.req = req; q.push_back(e);
        end else if (m_mode == 0) begin
            exp_tck = 1;
            e.tms = v; e.tdi = 1'b0; e.req = req; q.push_back(e);
        end else if (m_mode == 1) begin
            m_pos++;
            if (m_pos == 8 && v == 1'b0) m_len = 36;
            if (m_pos > m_len) begin
                m_mode = 2; m_slot = 1; m_tdi = 1'b0; exp_rst = 1;
            end else begin
                exp_tck = 1;
                e.tms = v; e.tdi = 1'b0; e.req = req; q.push_back(e);
            end
        end else begin
            if (m_slot == 0) begin
                m_tdi = ~v; m_slot = 1;
            end else if (m_slot == 1) begin
                m_tms = v; m_slot = 2;
            end else begin
                exp_tck = 1; m_slot = 0;
                e.tms = m_tms; e.tdi = m_tdi; e.req = req; q.push_back(e);
            end
        end
        esc = 0;
        @(negedge clk); tckc = 1'b0; tmsc = v;
        @(negedge clk); tckc = 1'b1;
        @(negedge clk);
        chk(req, int'(tap_tck), int'(exp_tck), "tap_tck");
        chk(req, int'(tap_reset), int'(exp_rst), "tap_reset");
        chk(req, int'(mode), m_mode, "mode");
        chk(req, int'(phase), (m_mode == 1) ? exp_phase(m_pos, m_len) : 0, "phase");
        chk(req, int'(tdo_slot), (m_mode == 2 && m_slot == 2) ? 1 : 0, "tdo_slot");
    endtask

    // Monitor: pops one expected item per observed TAP clock strobe.
    always @(negedge clk) begin
        if (rst_n && tap_tck && !done) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected tap_tck actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, int'(tap_tms), int'(e.tms), "tap_tms");
                chk(e.req, int'(tap_tdi), int'(e.tdi), "tap_tdi");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(mode), 0, "mode");
        chk("R1", int'(phase), 0, "phase");
        chk("R1", int'(tap_tck), 0, "tap_tck");
        chk("R1", int'(tap_tms), 0, "tap_tms");
        chk("R1", int'(tap_tdi), 0, "tap_tdi");
        chk("R1", int'(tdo_slot), 0, "tdo_slot");
        chk("R1", int'(tap_reset), 0, "tap_reset");

        // R2 pass-through
        bit_in(1'b1, "R2"); bit_in(1'b0, "R2"); bit_in(1'b1, "R2");
        bit_in(1'b1, "R2"); bit_in(1'b0, "R2");

        // R4 counts other than 6 or 8+ are ignored; R3 count of 8 forces four-wire
        toggle(4); bit_in(1'b1, "R4");
        toggle(8); bit_in(1'b0, "R3");

        // R4 enter activation, then R6 short code
        toggle(6); bit_in(1'b1, "R4");
        for (int i = 1; i <= 12; i++)
            bit_in((i == 8) ? 1'b1 : 1'(i % 2), "R6");
        bit_in(1'b0, "R8");

        // R10 first group (no slot 0), then full groups (R9)
        bit_in(1'b1, "R9"); bit_in(1'b0, "R10");
        bit_in(1'b0, "R9"); bit_in(1'b0, "R9"); bit_in(1'b1, "R10");
        bit_in(1'b1, "R9"); bit_in(1'b1, "R9"); bit_in(1'b0, "R10");
        bit_in(1'b0, "R9"); bit_in(1'b1, "R9"); bit_in(1'b0, "R10");

        // R11 escape of 8 on a slot-2 edge wins over the group
        bit_in(1'b0, "R9"); bit_in(1'b1, "R9");
        toggle(8); bit_in(1'b1, "R11");

        // R5/R7 long code with clear-after-evaluate check (R3)
        toggle(6); bit_in(1'b0, "R4");
        for (int i = 1; i <= 36; i++) begin
            if (i == 20 || i == 21) toggle(3);
            bit_in((i == 8) ? 1'b0 : 1'(i % 2), (i == 8) ? "R5" : ((i == 21) ? "R3" : "R7"));
        end
        bit_in(1'b1, "R8");

        // R9/R10 scan, with an ignored count of 7 on a slot-0 edge (R4)
        bit_in(1'b1, "R9"); bit_in(1'b0, "R10");
        toggle(7); bit_in(1'b0, "R4");
        bit_in(1'b0, "R9"); bit_in(1'b1, "R10");

        // R4 re-activation from scan, then R3 back to four-wire
        toggle(6); bit_in(1'b1, "R4");
        bit_in(1'b1, "R5");
        toggle(8); bit_in(1'b0, "R3");

        repeat (3) @(negedge clk);
        chk("R10", q.size(), 0, "pending pulses");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule